// File: doc/BRIEF.md
# Single-Level I/O Page Translator

This block turns a device-side DMA address into a system address at 4 KiB page granularity. Software programs a range base, a range mask and a table pointer through a simple register write/read port. A translation request arrives on a valid/ready stream. The request's offset bits are dropped first. If the range is switched on and the masked page address equals the range base, the block reads one 64-bit entry from a flat table in memory. The entry is found by the page number, and its top bit says whether it is valid. The block then answers with the translated page or with a fault. Pages outside the range, or any page while the range is switched off, come back unchanged.

The memory side is a read master that has at most one fetch outstanding. A fetch is a request handshake (`mem_req_valid`/`mem_req_ready`) followed later by a single-cycle `mem_rsp_valid` beat carrying the entry. Entry byte 0 sits in bits 7:0 of that beat.

Back-pressure works as follows. `req_ready` is high only while the block is idle, so a new request waits until the previous response has been taken. A response stays on the outputs, unchanged, while `rsp_ready` is low. A memory request stays asserted, with a stable address, until `mem_req_ready` is seen.

Top module: `iova_xlate`

## Requirements
- R1: After reset the five registers (range base, range mask, purge command, config, table pointer) read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The low 12 bits of the request address are cleared before use. `rsp_iova` returns that page address, and `rsp_offset_mask` is 0xFFF.
- R3: When bit 0 of the range base is 0, no memory read is issued. The response (`rsp_paddr` = page address, `rsp_fault` = 0) is valid in the cycle after the request is accepted.
- R4: When bit 0 of the range base is 1 but (page & mask) differs from the range base with bit 0 cleared, the request passes through as in R3.
- R5: When the range matches, exactly one memory read is issued, at address table pointer + (page address >> 12) × 8.
- R6: If bit 63 of the fetched entry is 0, the response has `rsp_fault` = 1 (no read/write permission) and `rsp_paddr` = 0.
- R7: If bit 63 of the fetched entry is 1, the response has `rsp_fault` = 0, and `rsp_paddr` is the entry with bit 63 and bits 11:0 cleared.
- R8: Register offsets (with `cfg_addr` bits 2:0 ignored on read) are: 0x300 range base, 0x308 range mask, 0x310 purge command (stored only), 0x318 config, 0x320 table pointer. Setting address bit 13 (+0x2000) reaches the same register.
- R9: With `cfg_wide` = 0, a write replaces one 32-bit half with `cfg_wdata[31:0]`, and the other half is kept. `cfg_addr` bit 2 = 1 selects bits 63:32, and 0 selects bits 31:0. With `cfg_wide` = 1, all 64 bits are written.
- R10: `req_ready` is 0 from acceptance until the response is taken. `rsp_*` hold steady while `rsp_ready` is 0. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. No response is valid while a fetch is pending.
- R11: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 18 | Register write byte offset |
| cfg_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit half write |
| cfg_wdata | input | 64 | Register write data |
| cfg_raddr | input | 18 | Register read byte offset |
| cfg_rdata | output | 64 | Register read data (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high |
| req_addr | input | 64 | Device-side address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high |
| rsp_iova | output | 64 | Page address of the request |
| rsp_paddr | output | 64 | Translated page address (0 on fault) |
| rsp_fault | output | 1 | Invalid entry: no read/write permission |
| rsp_offset_mask | output | 12 | In-page offset mask, always 0xFFF |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | 64 | Table entry byte address |
| mem_rsp_valid | input | 1 | Table read data beat |
| mem_rsp_data | input | 64 | Table entry, little-endian |

## Verification
The translator is swept over 80 consecutive pages that straddle both edges of a 64-page matching window. The walk therefore has to switch on exactly at the window boundary, and the table index has to track the full page number rather than the in-window offset. Fetched entries alternate between valid and invalid, and some carry bit 62, so a wrong valid-bit position or over-eager bit clearing shows up. A second pass leaves the window programmed but keeps the enable bit clear. This separates the enable test from the mask compare, and it checks the one-cycle passthrough latency. The memory side toggles its ready every cycle and the response side is held back, so the handshake hold rules are exercised on every lookup.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_t;

  localparam int NUM_REGS   = 5;
  localparam int REG_BASE   = 'h300;
  localparam int REG_STRIDE = 8;
  localparam int ALIAS_BIT  = 13;
endpackage

// File: rtl/xl_regs.sv
module xl_regs #(
  parameter int W   = 64,
  parameter int CAW = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CAW-1:0] wr_addr,
  input  logic           wr_wide,
  input  logic [W-1:0]   wr_data,
  input  logic [CAW-1:0] rd_addr,
  output logic [W-1:0]   rd_data,
  output logic [W-1:0]   range_base,
  output logic [W-1:0]   range_mask,
  output logic [W-1:0]   table_ptr
);
  import xl_pkg::*;
  localparam int HW = W / 2;
  localparam logic [CAW-1:0] IGNORE = CAW'(1) << ALIAS_BIT | CAW'(REG_STRIDE - 1);

  logic [W-1:0]   regs_q [NUM_REGS];
  logic [CAW-1:0] wr_norm, rd_norm;

  assign wr_norm = wr_addr & ~IGNORE;
  assign rd_norm = rd_addr & ~IGNORE;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [CAW-1:0] OFF = CAW'(REG_BASE + i * REG_STRIDE);
    logic [W-1:0] merged;
    always_comb begin
      if (wr_wide)          merged = wr_data;
      else if (wr_addr[2])  merged = {wr_data[HW-1:0], regs_q[i][HW-1:0]};
      else                  merged = {regs_q[i][W-1:HW], wr_data[HW-1:0]};
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                          regs_q[i] <= '0;
      else if (wr_en && wr_norm == OFF)    regs_q[i] <= merged;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_norm == CAW'(REG_BASE + i * REG_STRIDE)) rd_data = regs_q[i];
  end

  assign range_base = regs_q[0];
  assign range_mask = regs_q[1];
  assign table_ptr  = regs_q[4];
endmodule

// File: rtl/xl_range.sv
module xl_range #(
  parameter int W  = 64,
  parameter int PS = 12,
  parameter int ES = 3
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] range_base,
  input  logic [W-1:0] range_mask,
  input  logic [W-1:0] table_ptr,
  output logic [W-1:0] page,
  output logic         hit,
  output logic [W-1:0] entry_addr
);
  localparam logic [W-1:0] OFS_MASK = (W'(1) << PS) - W'(1);

  assign page       = addr & ~OFS_MASK;
  assign hit        = range_base[0] &&
                      ((page & range_mask) == {range_base[W-1:1], 1'b0});
  assign entry_addr = table_ptr + ((page >> PS) << ES);
endmodule

// File: rtl/xl_walker.sv
module xl_walker #(
  parameter int W  = 64,
  parameter int PS = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] page,
  input  logic         hit,
  input  logic [W-1:0] entry_addr,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_iova,
  output logic [W-1:0] rsp_paddr,
  output logic         rsp_fault,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic [W-1:0] mem_req_addr,
  input  logic         mem_rsp_valid,
  input  logic [W-1:0] mem_rsp_data
);
  import xl_pkg::*;
  localparam logic [W-1:0] OFS_MASK = (W'(1) << PS) - W'(1);

  walk_st_t     st_q;
  logic [W-1:0] page_q, maddr_q, paddr_q;
  logic         fault_q;
  logic         entry_ok;
  logic [W-1:0] entry_page;

  assign entry_ok   = mem_rsp_data[W-1];
  assign entry_page = {1'b0, mem_rsp_data[W-2:0]} & ~OFS_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      page_q  <= '0;
      maddr_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          page_q <= page;
          if (hit) begin
            maddr_q <= entry_addr;
            st_q    <= ST_FETCH;
          end else begin
            paddr_q <= page;
            fault_q <= 1'b0;
            st_q    <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          fault_q <= !entry_ok;
          paddr_q <= entry_ok ? entry_page : '0;
          st_q    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_req_addr  = maddr_q;
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_iova      = page_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate #(
  parameter int W   = 64,
  parameter int CAW = 18,
  parameter int PS  = 12,
  parameter int ES  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic           cfg_wide,
  input  logic [W-1:0]   cfg_wdata,
  input  logic [CAW-1:0] cfg_raddr,
  output logic [W-1:0]   cfg_rdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [W-1:0]   req_addr,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [W-1:0]   rsp_iova,
  output logic [W-1:0]   rsp_paddr,
  output logic           rsp_fault,
  output logic [PS-1:0]  rsp_offset_mask,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [W-1:0]   mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [W-1:0]   mem_rsp_data
);
  logic [W-1:0] range_base, range_mask, table_ptr, page, entry_addr;
  logic         hit;

  xl_regs #(.W(W), .CAW(CAW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_wide(cfg_wide), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
    .range_base(range_base), .range_mask(range_mask), .table_ptr(table_ptr)
  );

  xl_range #(.W(W), .PS(PS), .ES(ES)) u_range (
    .addr(req_addr), .range_base(range_base), .range_mask(range_mask),
    .table_ptr(table_ptr), .page(page), .hit(hit), .entry_addr(entry_addr)
  );

  xl_walker #(.W(W), .PS(PS)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .page(page), .hit(hit), .entry_addr(entry_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  assign rsp_offset_mask = '1;
endmodule

// File: rtl/xl_chk.sv
module xl_chk #(
  parameter int W  = 64,
  parameter int PS = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_iova,
  input logic [W-1:0] rsp_paddr,
  input logic         rsp_fault,
  input logic         mem_req_valid,
  input logic         mem_req_ready,
  input logic [W-1:0] mem_req_addr
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_iova)); // R10
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_iova[PS-1:0] == '0 && rsp_paddr[PS-1:0] == '0); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R6
  AST_VALID_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && rsp_paddr[W-1] |-> rsp_paddr == rsp_iova); // R7
endmodule

bind iova_xlate xl_chk #(.W(W), .PS(PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/tb_iova_xlate.sv
`timescale 1ns/1ps
module tb_iova_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_wide = 1'b0;
  logic [17:0] cfg_addr = '0, cfg_raddr = '0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
  logic [63:0] rsp_iova, rsp_paddr;
  logic [11:0] rsp_offset_mask;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] mem_req_addr, mem_rsp_data = '0;

  int errors = 0, checks = 0, nmem = 0;
  logic [63:0] last_maddr = '0;
  logic [63:0] b_base = '0, b_mask = '0, b_tbase = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  iova_xlate dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] entry_of(input logic [63:0] p);
    logic [63:0] e;
    e = ((p * 64'h9E37) << 12) | 64'hABC;
    if (p[0]) e = e | (64'h1 << 62);
    if ((p % 3) != 0) e = e | (64'h1 << 63);
    return e;
  endfunction

  // memory model: ready toggles every cycle, data one cycle after handshake
  initial begin
    bit issued = 0;
    forever begin
      @(negedge clk);
      if (issued) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = entry_of((last_maddr - b_tbase) >> 3);
        issued = 0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = ~mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        issued = 1;
        nmem++;
        last_maddr = mem_req_addr;
      end
    end
  end

  task automatic cfg_wr(input logic [17:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_wide = wide;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [17:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    cfg_raddr = a;
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic xlate(input logic [63:0] a);
    logic [63:0] pg, pn, e, exp_pa, held;
    bit hit;
    int n0;
    pg  = a & ~64'hFFF;
    pn  = pg >> 12;
    hit = b_base[0] && ((pg & b_mask) == (b_base & ~64'h1));
    n0  = nmem;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) chk(rsp_valid, "R3 passthrough response one cycle after accept", 64'(rsp_valid), 64'd1);
    while (!rsp_valid) @(negedge clk);
    chk(!req_ready, "R10 no accept while response pending", 64'(req_ready), 64'd0);
    held = rsp_paddr;
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == held, "R10 response held under back-pressure", rsp_paddr, held);
    chk(rsp_iova == pg, "R2 page address returned", rsp_iova, pg);
    chk(rsp_offset_mask == 12'hFFF, "R2 offset mask", 64'(rsp_offset_mask), 64'hFFF);
    if (hit) begin
      e = entry_of(pn);
      chk(nmem == n0 + 1, "R5 exactly one table read", 64'(nmem - n0), 64'd1);
      chk(last_maddr == b_tbase + pn * 8, "R5 entry address", last_maddr, b_tbase + pn * 8);
      if (e[63]) begin
        exp_pa = e & ~(64'h1 << 63) & ~64'hFFF;
        chk(!rsp_fault && rsp_paddr == exp_pa, "R7 translated page", rsp_paddr, exp_pa);
      end else begin
        chk(rsp_fault && rsp_paddr == 0, "R6 invalid entry faults", {rsp_paddr[62:0], rsp_fault}, 64'h1);
      end
    end else begin
      chk(nmem == n0, b_base[0] ? "R4 no read outside range" : "R3 no read when disabled", 64'(nmem - n0), 64'd0);
      chk(!rsp_fault && rsp_paddr == pg, b_base[0] ? "R4 passthrough" : "R3 passthrough", rsp_paddr, pg);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 response taken once", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle handshake state after reset",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
    for (int i = 0; i < 5; i++) cfg_rd(18'(18'h300 + i * 8), 64'd0, "R1 register reset to zero");

    // window programmed, enable clear
    cfg_wr(18'h300, 64'h0000_0000_0004_0000, 1); b_base = 64'h0004_0000;
    cfg_wr(18'h2308, 64'hFFFF_FFFF_FFFC_0000, 1); b_mask = 64'hFFFF_FFFF_FFFC_0000;
    cfg_rd(18'h308, b_mask, "R8 alias write reaches mask");
    for (int p = 'h3C; p < 'h48; p++) xlate(64'(p) << 12 | 64'(p * 19 & 'hFFF));
    xlate(64'hFFFF_0000_1234_5ABC);

    // table pointer by halves, base enabled by low half
    cfg_wr(18'h324, 64'hDEAD_0000_0000_0001, 0);
    cfg_wr(18'h2320, 64'h1234_5678_8000_0000, 0);
    b_tbase = 64'h0000_0001_8000_0000;
    cfg_rd(18'h320, b_tbase, "R9 half writes merge table pointer");
    cfg_wr(18'h300, 64'hFFFF_FFFF_0004_0001, 0); b_base = 64'h0004_0001;
    cfg_rd(18'h2300, b_base, "R9 low half write keeps upper half");
    for (int p = 'h38; p < 'h88; p++) xlate(64'(p) << 12 | 64'(p * 19 & 'hFFF));

    // stored-only registers, halves
    cfg_wr(18'h2310, 64'hA5A5_0000_1111_2222, 1);
    cfg_rd(18'h310, 64'hA5A5_0000_1111_2222, "R8 purge register via alias");
    cfg_wr(18'h318, 64'h0000_0000_CAFE_F00D, 1);
    cfg_wr(18'h31C, 64'h0000_0000_0BAD_BEEF, 0);
    cfg_rd(18'h318, 64'h0BAD_BEEF_CAFE_F00D, "R9 upper half write keeps lower half");

    // unmapped offsets
    cfg_wr(18'h328, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    cfg_wr(18'h1300, 64'h0, 1);
    cfg_wr(18'h2F8, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    cfg_rd(18'h328, 64'd0, "R11 unmapped read is zero");
    cfg_rd(18'h300, b_base, "R11 base untouched by unmapped writes");
    cfg_rd(18'h2F8, 64'd0, "R11 unmapped read below window");
    xlate(64'h0000_0000_0004_5123);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule